// File: doc/BRIEF.md
# Peripheral Request Mapper and Priority Arbiter

The block connects a set of peripheral transfer-request lines to a bank of DMA channels and chooses which channel may use the shared bus next. Each request line has its own small map register. Software writes into it a valid flag and a channel number. While the flag is set, the request line drives the request output of that channel. Several lines may target one channel, and their requests are ORed together. A 32-bit word in the same register space shows, one bit per channel, which channels are raising an interrupt.

Arbitration runs every cycle among the channels whose active input is high, and at most one grant is issued. Bits 3:2 of a channel's index give its priority level, so channels 0-3 and 16-19 share the top level and channels 12-15 and 28-31 share the bottom one. The top non-empty level always wins. Inside that level, eligible channels take turns in round-robin order. The arbiter is a two-state machine. ARB_IDLE means no grant is driven. ARB_GRANT means a one-hot grant is driven for the channel chosen at the last edge. The transition into ARB_GRANT (or a stay in it) happens at every edge where some channel is active. The transition back to ARB_IDLE happens at an edge where no channel is active.

Top module: `dreq_mapper_arb`

## Requirements
- R1: Each map register keeps the valid flag in bit 7 and the channel number in bits 4:0. A read returns exactly those bits and returns the other bits as zero. Every map register resets to zero, and a read returns its data on reg_rdata_o the cycle after reg_ren_i.
- R2: The map register for request n sits at byte address 0x100+4n when n is below 64, and at 0x1100+4(n-64) when n is 64 or more. An address for a request number at or above NUM_REQ has no effect on writes and reads as zero.
- R3: A high request line whose map register has the valid flag set raises chan_req_o of the mapped channel one clock edge later. A line whose valid flag is clear, or whose map register has been written with zero, drives no channel.
- R4: When several valid map registers target the same channel, their request lines are ORed onto that channel's request output.
- R5: grant_o is zero or one-hot. It appears one edge after chan_active_i, only for a channel that was active at that edge, and it is zero after an edge at which no channel was active.
- R6: The priority level of a channel is bits 3:2 of its index, and level 0 is the highest. A grant never goes to a channel while a channel on a higher level was active.
- R7: Within the winning level, the grant goes to the next active channel of that level in ascending index order, wrapping around, after the channel that level granted last. After reset the search starts at channel 0.
- R8: A read of address 0x0F0 returns the interrupt summary. Bit c equals chan_irq_i[c].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wen_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_ren_i | input | 1 | Register read strobe |
| reg_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| periph_req_i | input | NUM_REQ | Peripheral request lines |
| chan_active_i | input | NUM_CH | Channel has work and competes for the bus |
| chan_irq_i | input | NUM_CH | Per-channel pending interrupt |
| chan_req_o | output | NUM_CH | Per-channel mapped request |
| grant_o | output | NUM_CH | One-hot bus grant |

## Verification
Every result of this block lands exactly one clock edge after its cause: the registered request outputs, the grant, and read data. A map write becomes effective at the edge that accepts it. The bench therefore changes inputs on the falling edge and reads outputs two nanoseconds after the next rising edge. Expected grants go into a queue, and the monitor pops one entry per rising edge. Each grant sequence starts on the same falling edge where the active set changes, so no unchecked cycle can move the round-robin pointers between sequences.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
    typedef enum logic [0:0] {ARB_IDLE, ARB_GRANT} arb_state_e;

    localparam int LEVELS        = 4;
    localparam int BANK_SPAN     = 64;
    localparam int BANK0_BASE    = 32'h0000_0100;
    localparam int BANK1_BASE    = 32'h0000_1100;
    localparam int IRQ_SUM_ADDR  = 32'h0000_00F0;
    localparam int MAP_VALID_BIT = 7;
    localparam int MAP_CHAN_W    = 5;

    // priority level is taken from index bits 3:2
    function automatic logic [1:0] level_of(input int ch);
        return ch[3:2];
    endfunction
endpackage

// File: rtl/dreq_map_regs.sv
module dreq_map_regs
    import dreq_pkg::*;
#(
    parameter int NUM_REQ = 96,
    parameter int NUM_CH  = 32,
    parameter int ADDR_W  = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   reg_addr_i,
    input  logic                                reg_wen_i,
    input  logic [31:0]                         reg_wdata_i,
    input  logic                                reg_ren_i,
    input  logic [NUM_CH-1:0]                   chan_irq_i,
    output logic [31:0]                         reg_rdata_o,
    output logic [NUM_REQ-1:0]                  map_vld_o,
    output logic [NUM_REQ-1:0][MAP_CHAN_W-1:0]  map_chan_o
);
    localparam int REQ_W   = $clog2(NUM_REQ);
    localparam int BANK0_N = (NUM_REQ < BANK_SPAN) ? NUM_REQ : BANK_SPAN;
    localparam int BANK1_N = (NUM_REQ > BANK_SPAN) ? NUM_REQ - BANK_SPAN : 0;

    logic             dec_hit;
    logic [REQ_W-1:0] dec_idx;
    int unsigned      a;

    always_comb begin
        a       = 32'(reg_addr_i);
        dec_hit = 1'b0;
        dec_idx = '0;
        if (a[1:0] == 2'b00) begin
            if (a >= BANK0_BASE && a < BANK0_BASE + 4 * BANK0_N) begin
                dec_hit = 1'b1;
                dec_idx = REQ_W'((a - BANK0_BASE) >> 2);
            end else if (BANK1_N > 0 && a >= BANK1_BASE && a < BANK1_BASE + 4 * BANK1_N) begin
                dec_hit = 1'b1;
                dec_idx = REQ_W'(BANK_SPAN + ((a - BANK1_BASE) >> 2));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_vld_o  <= '0;
            map_chan_o <= '0;
        end else if (reg_wen_i && dec_hit) begin
            map_vld_o[dec_idx]  <= reg_wdata_i[MAP_VALID_BIT];
            map_chan_o[dec_idx] <= reg_wdata_i[MAP_CHAN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata_o <= '0;
        end else if (reg_ren_i) begin
            if (a == IRQ_SUM_ADDR)
                reg_rdata_o <= 32'(chan_irq_i);
            else if (dec_hit)
                reg_rdata_o <= {24'h0, map_vld_o[dec_idx], 2'b00, map_chan_o[dec_idx]};
            else
                reg_rdata_o <= '0;
        end
    end
endmodule

// File: rtl/dreq_router.sv
module dreq_router
    import dreq_pkg::*;
#(
    parameter int NUM_REQ = 96,
    parameter int NUM_CH  = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_REQ-1:0]                  periph_req_i,
    input  logic [NUM_REQ-1:0]                  map_vld_i,
    input  logic [NUM_REQ-1:0][MAP_CHAN_W-1:0]  map_chan_i,
    output logic [NUM_CH-1:0]                   chan_req_o
);
    logic [NUM_CH-1:0] req_d;

    always_comb begin
        req_d = '0;
        for (int r = 0; r < NUM_REQ; r++) begin
            if (map_vld_i[r] && periph_req_i[r] && (int'(map_chan_i[r]) < NUM_CH))
                req_d[map_chan_i[r]] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_req_o <= '0;
        else        chan_req_o <= req_d;
    end
endmodule

// File: rtl/dreq_arbiter.sv
module dreq_arbiter
    import dreq_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_active_i,
    output logic [NUM_CH-1:0] grant_o
);
    localparam int CH_W = $clog2(NUM_CH);

    arb_state_e        state_q, state_d;
    logic [CH_W-1:0]   gnt_ch_q;
    logic [CH_W-1:0]   ptr_q [LEVELS];
    logic [LEVELS-1:0] lvl_any;
    logic [1:0]        sel_lvl;
    logic [CH_W-1:0]   win;
    logic              win_ok;

    always_comb begin
        lvl_any = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (chan_active_i[c]) lvl_any[level_of(c)] = 1'b1;
        sel_lvl = 2'd0;
        for (int l = LEVELS - 1; l >= 0; l--)
            if (lvl_any[l]) sel_lvl = 2'(l);
        win    = '0;
        win_ok = 1'b0;
        for (int i = 1; i <= NUM_CH; i++) begin
            int c;
            c = (int'(ptr_q[sel_lvl]) + i) % NUM_CH;
            if (!win_ok && chan_active_i[c] && level_of(c) == sel_lvl) begin
                win    = CH_W'(c);
                win_ok = 1'b1;
            end
        end
        state_d = win_ok ? ARB_GRANT : ARB_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ARB_IDLE;
            gnt_ch_q <= '0;
            for (int l = 0; l < LEVELS; l++) ptr_q[l] <= CH_W'(NUM_CH - 1);
        end else begin
            state_q <= state_d;
            if (win_ok) begin
                gnt_ch_q       <= win;
                ptr_q[sel_lvl] <= win;
            end
        end
    end

    always_comb begin
        grant_o = '0;
        unique case (state_q)
            ARB_IDLE:  grant_o = '0;
            ARB_GRANT: grant_o[gnt_ch_q] = 1'b1;
            default:   grant_o = '0;
        endcase
    end
endmodule

// File: rtl/dreq_mapper_arb.sv
module dreq_mapper_arb
    import dreq_pkg::*;
#(
    parameter int NUM_REQ = 96,
    parameter int NUM_CH  = 32,
    parameter int ADDR_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               reg_wen_i,
    input  logic [31:0]        reg_wdata_i,
    input  logic               reg_ren_i,
    output logic [31:0]        reg_rdata_o,
    input  logic [NUM_REQ-1:0] periph_req_i,
    input  logic [NUM_CH-1:0]  chan_active_i,
    input  logic [NUM_CH-1:0]  chan_irq_i,
    output logic [NUM_CH-1:0]  chan_req_o,
    output logic [NUM_CH-1:0]  grant_o
);
    logic [NUM_REQ-1:0]                 map_vld;
    logic [NUM_REQ-1:0][MAP_CHAN_W-1:0] map_chan;

    dreq_map_regs #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr_i), .reg_wen_i(reg_wen_i),
        .reg_wdata_i(reg_wdata_i), .reg_ren_i(reg_ren_i), .chan_irq_i(chan_irq_i),
        .reg_rdata_o(reg_rdata_o), .map_vld_o(map_vld), .map_chan_o(map_chan)
    );

    dreq_router #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_router (
        .clk(clk), .rst_n(rst_n), .periph_req_i(periph_req_i),
        .map_vld_i(map_vld), .map_chan_i(map_chan), .chan_req_o(chan_req_o)
    );

    dreq_arbiter #(.NUM_CH(NUM_CH)) u_arb (
        .clk(clk), .rst_n(rst_n), .chan_active_i(chan_active_i), .grant_o(grant_o)
    );
endmodule

// File: rtl/dreq_mapper_arb_chk.sv
module dreq_mapper_arb_chk
    import dreq_pkg::*;
#(
    parameter int NUM_REQ = 96,
    parameter int NUM_CH  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] periph_req_i,
    input logic [NUM_CH-1:0]  chan_active_i,
    input logic [NUM_CH-1:0]  chan_req_o,
    input logic [NUM_CH-1:0]  grant_o
);
    logic [1:0]        glvl;
    logic [NUM_CH-1:0] hi_mask;

    always_comb begin
        glvl = 2'd0;
        for (int c = 0; c < NUM_CH; c++)
            if (grant_o[c]) glvl = level_of(c);
        for (int c = 0; c < NUM_CH; c++)
            hi_mask[c] = (level_of(c) < glvl);
    end

    p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    p_grant_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o) |-> ((grant_o & $past(chan_active_i)) == grant_o));

    p_grant_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_active_i) |=> (|grant_o));

    p_no_grant_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(|chan_active_i) |=> (grant_o == '0));

    p_level_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o) |-> (($past(chan_active_i) & hi_mask) == '0));

    p_req_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_req_o) |-> $past(|periph_req_i));
endmodule

bind dreq_mapper_arb dreq_mapper_arb_chk #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .periph_req_i(periph_req_i),
    .chan_active_i(chan_active_i), .chan_req_o(chan_req_o), .grant_o(grant_o)
);

// File: tb/tb_dreq_mapper_arb.sv
module tb_dreq_mapper_arb;
    localparam int NUM_REQ = 96;
    localparam int NUM_CH  = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [15:0]        reg_addr_i = '0;
    logic               reg_wen_i = 1'b0;
    logic [31:0]        reg_wdata_i = '0;
    logic               reg_ren_i = 1'b0;
    logic [31:0]        reg_rdata_o;
    logic [NUM_REQ-1:0] periph_req_i = '0;
    logic [NUM_CH-1:0]  chan_active_i = '0;
    logic [NUM_CH-1:0]  chan_irq_i = '0;
    logic [NUM_CH-1:0]  chan_req_o;
    logic [NUM_CH-1:0]  grant_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    dreq_mapper_arb #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(16)) dut (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [15:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_addr_i = addr; reg_wdata_i = data; reg_wen_i = 1'b1;
        @(negedge clk);
        reg_wen_i = 1'b0;
    endtask

    task automatic reg_read(input logic [15:0] addr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr_i = addr; reg_ren_i = 1'b1;
        @(posedge clk); #2;
        check(reg_rdata_o == exp, tag, reg_rdata_o, exp);
        reg_ren_i = 1'b0;
    endtask

    task automatic req_check(input logic [NUM_REQ-1:0] reqs, input logic [31:0] exp, input string tag);
        @(negedge clk);
        periph_req_i = reqs;
        @(posedge clk); #2;
        check(chan_req_o == exp, tag, chan_req_o, exp);
    endtask

    // driver: called on a falling edge; pushes expected grants, holds active set
    task automatic run_arb(input logic [31:0] act, input int n, input logic [31:0] e0,
                           input logic [31:0] e1, input logic [31:0] e2,
                           input logic [31:0] e3, input string tag);
        logic [31:0] e [4];
        e = '{e0, e1, e2, e3};
        chan_active_i = act;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(e[i]);
            tag_q.push_back(tag);
        end
        repeat (n) @(negedge clk);
        chan_active_i = '0;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk); #2;
            if (exp_q.size() > 0) begin
                logic [31:0] ex;
                string t;
                ex = exp_q.pop_front();
                t  = tag_q.pop_front();
                check(grant_o == ex, t, grant_o, ex);
            end
        end
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check(grant_o == '0, "R5 reset grant", grant_o, 0);
        check(chan_req_o == '0, "R3 reset req", chan_req_o, 0);
        reg_read(16'h0108, 32'h0, "R1 reset map zero");

        // R1/R2 map layout and addressing
        reg_write(16'h0108, 32'hFFFF_FF85);            // req 2 -> ch5 valid
        reg_read(16'h0108, 32'h85, "R1 readback masks other bits");
        reg_write(16'h1118, 32'h0000_0085);            // req 70 -> ch5 valid
        reg_read(16'h1118, 32'h85, "R2 second bank readback");
        reg_write(16'h010C, 32'h0000_006A);            // req 3 -> ch10, valid clear
        reg_read(16'h010C, 32'h0A, "R1 valid clear readback");
        reg_write(16'h1180, 32'h0000_0081);            // req 96: beyond NUM_REQ
        reg_read(16'h1180, 32'h0, "R2 out of range ignored");
        reg_write(16'h0128, 32'h0000_0086);            // req 10 -> ch6 valid

        // R3/R4 routing
        req_check(96'h4, 32'h0000_0020, "R3 req2 to ch5");
        req_check(96'h8, 32'h0, "R3 invalid map drives nothing");
        req_check(96'h1 << 70, 32'h0000_0020, "R2 req70 bank1 to ch5");
        req_check((96'h1 << 70) | 96'h4, 32'h0000_0020, "R4 two requests OR on ch5");
        req_check((96'h1 << 70) | 96'h404, 32'h0000_0060, "R4 separate channels");
        reg_write(16'h0108, 32'h0);
        req_check(96'h4, 32'h0, "R3 zero write unmaps");
        req_check('0, 32'h0, "R3 idle");

        // R8 interrupt summary
        chan_irq_i = 32'hA500_0003;
        reg_read(16'h00F0, 32'hA500_0003, "R8 irq summary");
        chan_irq_i = 32'h0000_8000;
        reg_read(16'h00F0, 32'h0000_8000, "R8 irq summary single");

        // arbitration
        @(negedge clk);
        run_arb(32'h0001_0023, 4, 32'h1, 32'h2, 32'h0001_0000, 32'h1, "R7 level0 round robin");
        run_arb(32'h0010_00A0, 4, 32'h20, 32'h80, 32'h0010_0000, 32'h20, "R7 level1 round robin");
        run_arb(32'h0000_2200, 3, 32'h200, 32'h200, 32'h200, 32'h0, "R6 level2 beats level3");
        run_arb(32'h0002_0012, 3, 32'h2, 32'h0002_0000, 32'h2, 32'h0, "R7 pointer kept per level");
        run_arb(32'h1000_0008, 2, 32'h8, 32'h8, 32'h0, 32'h0, "R6 level0 beats level3");
        run_arb(32'h0, 2, 32'h0, 32'h0, 32'h0, 32'h0, "R5 idle no grant");
        repeat (3) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule